// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the host's synchronized transmit-data line and the enable of a single-wire bus driver. A low transmit level asks for a dominant (driven-low) bus and a high level leaves the bus recessive. The guard passes that request through to the driver, but only while communication is enabled. It stops a transmit line that is stuck low from holding the shared bus dominant without limit.

The guard measures a continuous dominant request in ticks of a programmable prescaler. When the request reaches the timeout, the driver is forced recessive and a timeout flag latches. A fresh rising edge does not clear the flag. It clears only after transmit-data has stayed high for a minimum release time, also counted in ticks. After that, normal transmission may start again. The default counts give a 10 ms timeout and an 11 µs release time with a 1 µs tick.

Top module: `txd_dom_guard`

## Requirements
- R1: `drv_en` is 1 exactly when `comm_en` is 1, `txd_sync` is 0 and `to_flag` is 0. It follows `txd_sync` and `comm_en` in the same cycle, without a register stage.
- R2: While `rst_n` is low, `to_flag` is 0 and both the dominant and the release counts are zero. A dominant request that continues after reset is timed from the first edge after reset.
- R3: If `txd_sync` is low and `comm_en` is high on DOM_TICKS consecutive ticks, with no high sample in between, `to_flag` goes to 1 at the clock edge of the last of those ticks. From then on `drv_en` is 0.
- R4: Any clock edge that samples `txd_sync` high before the timeout is reached restarts the dominant count from zero.
- R5: While `to_flag` is 1, `drv_en` stays 0 whatever the levels of `txd_sync` and `comm_en`. A high period shorter than REL_TICKS ticks leaves `to_flag` set and restarts the release count.
- R6: `to_flag` returns to 0 at the clock edge of the REL_TICKS-th consecutive tick on which `txd_sync` is sampled high. The level of `comm_en` has no effect on this release.
- R7: While `comm_en` is 0, no dominant time builds up. A later enable starts the count from zero.
- R8: One tick occurs every `tick_div`+1 clock cycles. A `tick_div` of 0 makes every clock cycle a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_sync | input | 1 | Synchronized transmit data: 0 requests dominant, 1 requests recessive |
| comm_en | input | 1 | High while the transceiver is in normal communicating mode |
| tick_div | input | PRE_W | Prescale value: tick period is tick_div+1 clock cycles |
| drv_en | output | 1 | Turns the bus driver on (bus dominant) |
| to_flag | output | 1 | Dominant timeout latched |

## Verification
The bench builds the guard with a timeout of 8 ticks, a release time of 3 ticks and an 8-bit prescaler. These small values let each timeout, release and restart edge be checked on the exact clock cycle, not only inside a wide window. Most scenarios run with `tick_div` at 0, so that ticks and clock cycles are the same. One scenario sets a prescale of 3 and checks the edge at which the flag latches once the tick period is four cycles long.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;

   // bits needed to hold values 0..n
   function automatic int tg_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/txd_tick_gen.sv
module txd_tick_gen #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);

   logic [PRE_W-1:0] cnt_q;

   // ">=" keeps the period bounded if div shrinks below the running count
   assign tick = (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/txd_dwell_cnt.sv
module txd_dwell_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic hit
);

   generate
      if (LIMIT == 1) begin : g_direct
         // one tick is enough: no storage needed
         assign hit = run & tick;
      end else begin : g_count
         localparam int W = txd_guard_pkg::tg_width(LIMIT - 1);
         localparam logic [W-1:0] LAST = W'(LIMIT - 1);
         logic [W-1:0] cnt_q;

         assign hit = run & tick & (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run)
               cnt_q <= '0;
            else if (tick)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
   parameter int DOM_TICKS = 10000,
   parameter int REL_TICKS = 11,
   parameter int PRE_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txd_sync,
   input  logic             comm_en,
   input  logic [PRE_W-1:0] tick_div,
   output logic             drv_en,
   output logic             to_flag
);

   generate
      if (DOM_TICKS < 2) begin : g_bad_dom
         $error("DOM_TICKS must be at least 2");
      end
      if (REL_TICKS < 1) begin : g_bad_rel
         $error("REL_TICKS must be at least 1");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("PRE_W must be at least 1");
      end
   endgenerate

   logic tick;
   logic latched_q;
   logic dom_run, dom_hit;
   logic rel_run, rel_hit;

   txd_tick_gen #(.PRE_W(PRE_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (tick_div),
      .tick (tick)
   );

   assign dom_run = comm_en & ~txd_sync & ~latched_q;
   assign rel_run = latched_q & txd_sync;

   txd_dwell_cnt #(.LIMIT(DOM_TICKS)) u_dom (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .run  (dom_run),
      .hit  (dom_hit)
   );

   txd_dwell_cnt #(.LIMIT(REL_TICKS)) u_rel (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .run  (rel_run),
      .hit  (rel_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latched_q <= 1'b0;
      else if (dom_hit)
         latched_q <= 1'b1;
      else if (rel_hit)
         latched_q <= 1'b0;
   end

   assign drv_en  = comm_en & ~txd_sync & ~latched_q;
   assign to_flag = latched_q;

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
   parameter int DOM_TICKS = 10000,
   parameter int REL_TICKS = 11
) (
   input logic clk,
   input logic rst_n,
   input logic txd_sync,
   input logic comm_en,
   input logic tick,
   input logic drv_en,
   input logic to_flag
);

   localparam int SW = txd_guard_pkg::tg_width(DOM_TICKS) + 1;
   localparam int RW = txd_guard_pkg::tg_width(REL_TICKS) + 1;

   logic [SW-1:0] sh_dom;
   logic [RW-1:0] sh_rel;

   // independent tallies of dominant and release ticks, seen from the ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_dom <= '0;
         sh_rel <= '0;
      end else begin
         if (!(comm_en && !txd_sync))
            sh_dom <= '0;
         else if (!to_flag && tick)
            sh_dom <= sh_dom + 1'b1;
         if (!(to_flag && txd_sync))
            sh_rel <= '0;
         else if (tick)
            sh_rel <= sh_rel + 1'b1;
      end
   end

   // R1
   drv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (comm_en && !txd_sync && !to_flag));

   // R3
   dom_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_dom >= SW'(DOM_TICKS)) |-> to_flag);

   // R3
   set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> $past(comm_en && !txd_sync));

   // R5
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !txd_sync) |=> to_flag);

   // R6
   release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_flag) |-> ($past(txd_sync) && $past(tick) && $past(sh_rel) == RW'(REL_TICKS - 1)));

endmodule

bind txd_dom_guard txd_dom_guard_chk #(
   .DOM_TICKS(DOM_TICKS),
   .REL_TICKS(REL_TICKS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .txd_sync(txd_sync),
   .comm_en (comm_en),
   .tick    (tick),
   .drv_en  (drv_en),
   .to_flag (to_flag)
);

// File: tb/txd_dom_guard_test.sv
module txd_dom_guard_test;

   localparam int DT = 8;
   localparam int RT = 3;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          txd = 1'b1;
   logic          en = 1'b0;
   logic [PW-1:0] div = '0;
   logic          drv;
   logic          flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   txd_dom_guard #(.DOM_TICKS(DT), .REL_TICKS(RT), .PRE_W(PW)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .txd_sync(txd),
      .comm_en (en),
      .tick_div(div),
      .drv_en  (drv),
      .to_flag (flag)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle();
      txd = 1'b1; en = 1'b1; div = '0;
      cyc(RT + 2);
   endtask

   task automatic t_reset();
      cyc(3);
      chk("R2", "flag in reset", flag, 1'b0);
      rst_n = 1'b1;
      cyc(2);
      chk("R2", "flag after reset", flag, 1'b0);
      chk("R1", "drv with txd high", drv, 1'b0);
   endtask

   task automatic t_timeout();
      settle();
      txd = 1'b0;
      #1 chk("R1", "drv follows low txd", drv, 1'b1);
      cyc(DT - 1);
      chk("R3", "flag one tick early", flag, 1'b0);
      chk("R1", "drv before timeout", drv, 1'b1);
      cyc(1);
      chk("R3", "flag at timeout", flag, 1'b1);
      chk("R3", "drv at timeout", drv, 1'b0);
      cyc(5);
      chk("R5", "drv held off", drv, 1'b0);
      txd = 1'b1;
      cyc(RT - 1);
      chk("R6", "flag before release", flag, 1'b1);
      cyc(1);
      chk("R6", "flag at release", flag, 1'b0);
      txd = 1'b0;
      #1 chk("R1", "drv after release", drv, 1'b1);
   endtask

   task automatic t_short_high();
      settle();
      txd = 1'b0; cyc(DT);
      chk("R3", "latched", flag, 1'b1);
      txd = 1'b1; cyc(RT - 1);
      txd = 1'b0; cyc(1);
      chk("R5", "flag after short high", flag, 1'b1);
      chk("R5", "drv after short high", drv, 1'b0);
      txd = 1'b1; cyc(RT - 1);
      chk("R5", "release count restarted", flag, 1'b1);
      cyc(1);
      chk("R6", "full release clears", flag, 1'b0);
   endtask

   task automatic t_restart();
      settle();
      txd = 1'b0; cyc(DT - 1);
      txd = 1'b1; cyc(1);
      txd = 1'b0; cyc(DT - 1);
      chk("R4", "no timeout after restart", flag, 1'b0);
      chk("R4", "drv still on", drv, 1'b1);
      cyc(1);
      chk("R4", "timeout after full run", flag, 1'b1);
   endtask

   task automatic t_comm_off();
      settle();
      en = 1'b0; txd = 1'b0;
      cyc(3 * DT);
      chk("R7", "no timeout while disabled", flag, 1'b0);
      chk("R1", "drv off while disabled", drv, 1'b0);
      en = 1'b1;
      #1 chk("R1", "drv on when enabled", drv, 1'b1);
      cyc(DT - 1);
      chk("R7", "count started at enable", flag, 1'b0);
      cyc(1);
      chk("R7", "timeout after enable", flag, 1'b1);
      en = 1'b0; txd = 1'b1;
      cyc(RT);
      chk("R6", "release with comm off", flag, 1'b0);
   endtask

   task automatic t_prescale();
      settle();
      div = 8'd3; txd = 1'b0;
      cyc(4 * DT - 1);
      chk("R8", "flag before 8th slow tick", flag, 1'b0);
      cyc(1);
      chk("R8", "flag at 8th slow tick", flag, 1'b1);
      div = '0;
   endtask

   task automatic t_mid_reset();
      settle();
      txd = 1'b0; cyc(DT);
      chk("R3", "latched before reset", flag, 1'b1);
      rst_n = 1'b0; cyc(1);
      chk("R2", "reset clears flag", flag, 1'b0);
      rst_n = 1'b1;
      cyc(DT - 1);
      chk("R2", "count restarts after reset", flag, 1'b0);
      cyc(1);
      chk("R2", "timeout after reset", flag, 1'b1);
   endtask

   initial begin
      t_reset();
      t_timeout();
      t_short_high();
      t_restart();
      t_comm_off();
      t_prescale();
      t_mid_reset();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule